// File: doc/BRIEF.md
# Serial Control and Status Shifter

This block is the digital front end of a serially controlled output driver. An external host selects it by pulling chip select low and then clocks in a 16-bit control word on the data input, least significant bit first, sampled on each falling serial clock edge. At the same time the block returns a 16-bit status word on the data output, also least significant bit first, advancing on rising serial clock edges. The status word is captured from external fault and state inputs at the moment chip select falls. Its bit 0 is the temperature prewarning flag, so a host can read that one flag by lowering and raising chip select without clocking at all.

The serial pins are asynchronous to the system clock. The block passes them through two-flop synchronizers and finds edges in the synchronized copies, so the serial clock must be several times slower than the system clock. The received word goes into the command register only when chip select rises after exactly 16 falling clock edges. Any other count discards the frame. The status-reset request bit becomes a single-cycle pulse and is never held as a level.

Top module: `ctl_status_shifter`

## Requirements
- R1: After synchronous reset the command word reads 16'hE000, the status-clear pulse is low and the data output enable is low.
- R2: The data output enable is high only while the synchronized chip select is low. While the enable is low the data output reads 0.
- R3: Once chip select has fallen, the data output shows status bit 0 (the prewarning input) before any serial clock edge occurs.
- R4: The status word is {supply_fail, inhibit, short_det, 6'b0, out_state[5:0], prewarn} (bit 15 down to bit 0). Bit 0 stays on the output through the first rising serial clock edge. Each later rising edge in the frame advances the output by one bit, least significant first.
- R5: Data input bits are sampled on falling serial clock edges, first bit received into bit 0. The command word keeps bits 1-6 (output on commands), bit 13 (open-load enable, active low), bit 14 (long delay select) and bit 15 (run). It always reads 0 in bits 0 and 7-12.
- R6: A chip select rise after fewer than 16 falling clock edges, including none, leaves the command word unchanged and produces no status-clear pulse.
- R7: A chip select rise after more than 16 falling clock edges also discards the frame.
- R8: A committed frame with bit 0 set produces a status-clear pulse exactly one system clock long. Bit 0 is never stored in the command word.
- R9: Changes on the status inputs after chip select has fallen do not alter the word shifted out in that frame.
- R10: The command word does not change during a frame until chip select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csn_in | input | 1 | Asynchronous chip select, active low |
| sclk_in | input | 1 | Asynchronous serial clock, idle low |
| sdi_in | input | 1 | Serial data input |
| sdo_out | output | 1 | Serial data output value |
| sdo_oe | output | 1 | Output enable for the serial data pad |
| prewarn | input | 1 | Temperature prewarning flag |
| out_state | input | 6 | Per-output state or open-load flags |
| short_det | input | 1 | Short-circuit detected flag |
| inhibit | input | 1 | Inhibit state flag |
| supply_fail | input | 1 | Supply fail flag |
| cmd_word | output | 16 | Committed command register |
| status_clr | output | 1 | One-cycle status-reset request pulse |

## Verification
The assertions rely on the serial pins being slow compared with the system clock. Each level must hold for several system clocks, so that each synchronized edge is seen once and a chip select edge never falls in the same cycle as a serial clock edge. The bench holds every serial pin level for eight system clocks and changes pins only on the falling system clock edge. It keeps the serial clock low whenever it moves chip select, so the one-edge-per-cycle assumption behind the pulse-width and hold properties stays true.

// File: rtl/css_pkg.sv
// Package: shared constants and status word packing for the serial
// control/status shifter. Assumes a 16-bit frame.
package css_pkg;
    localparam int FRAME_BITS = 16;
    localparam int CNT_W      = $clog2(FRAME_BITS + 2);
    localparam logic [FRAME_BITS-1:0] CMD_RESET = 16'hE000;
    localparam logic [FRAME_BITS-1:0] CMD_KEEP  = 16'hE07E;
    localparam int NUM_OUT = 6;

    // Packs the live fault/state flags into the transmitted status layout.
    function automatic logic [FRAME_BITS-1:0] pack_status(
        input logic pw, input logic [NUM_OUT-1:0] st,
        input logic sc, input logic inh, input logic sf);
        return {sf, inh, sc, 6'b0, st, pw};
    endfunction
endpackage

// File: rtl/css_sync.sv
// Module: two-flop synchronizer bank. Each bit has its own reset value.
// Assumes the inputs are asynchronous levels that are slow compared with clk.
module css_sync #(
    parameter int WIDTH = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_bit
            logic s1, s2;
            // Two-stage capture of one asynchronous bit.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    s1 <= RST_VAL[g];
                    s2 <= RST_VAL[g];
                end else begin
                    s1 <= d_async[g];
                    s2 <= s1;
                end
            end
            assign q_sync[g] = s2;
        end
    endgenerate
endmodule

// File: rtl/css_rx.sv
// Module: receive shifter, bit counter and command register.
// Assumes the edge strobes are single-cycle and mutually exclusive.
module css_rx
    import css_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_fall,
    input  logic                  cs_rise,
    input  logic                  sclk_fall,
    input  logic                  di,
    output logic [CNT_W-1:0]      bit_cnt,
    output logic [FRAME_BITS-1:0] cmd_q,
    output logic                  clr_pulse
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_BITS + 1);

    logic [FRAME_BITS-1:0] rx_sh;
    logic                  frame_ok;

    assign frame_ok = cs_rise && (bit_cnt == CNT_FULL);

    // Shift data in LSB first and count edges, saturating past a full frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sh   <= '0;
            bit_cnt <= '0;
        end else if (cs_fall) begin
            rx_sh   <= '0;
            bit_cnt <= '0;
        end else if (sclk_fall) begin
            rx_sh   <= {di, rx_sh[FRAME_BITS-1:1]};
            if (bit_cnt != CNT_OVER) bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // Commit a complete frame on chip select rise and pulse the clear request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q     <= CMD_RESET;
            clr_pulse <= 1'b0;
        end else begin
            clr_pulse <= frame_ok && rx_sh[0];
            if (frame_ok) cmd_q <= rx_sh & CMD_KEEP;
        end
    end

    // Frames of the wrong length must not touch the command register.
    assert_abort_keeps_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && bit_cnt < CNT_FULL) |=> $stable(cmd_q));
    assert_long_frame_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && bit_cnt == CNT_OVER) |=> $stable(cmd_q));
    assert_clear_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pulse |=> !clr_pulse);
    assert_cmd_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_rise |=> $stable(cmd_q));
    // The counter saturates one past a full frame.
    always_comb begin
        if (rst_n) assert_cnt_bound_R7: assert (bit_cnt <= CNT_OVER);
    end
endmodule

// File: rtl/css_tx.sv
// Module: transmit shifter with output enable. Loads the status snapshot when
// chip select falls and holds bit 0 through the first rising clock edge.
// Assumes single-cycle, mutually exclusive edge strobes.
module css_tx
    import css_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_low,
    input  logic                  cs_fall,
    input  logic                  cs_rise,
    input  logic                  sclk_rise,
    input  logic                  cnt_nz,
    input  logic [FRAME_BITS-1:0] status_word,
    output logic                  sdo_out,
    output logic                  sdo_oe
);
    logic [FRAME_BITS-1:0] tx_sh;
    logic                  oe_q;

    // Snapshot on frame start, then shift right on later rising clock edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh <= '0;
        end else if (cs_fall) begin
            tx_sh <= status_word;
        end else if (sclk_rise && cs_low && cnt_nz) begin
            tx_sh <= {1'b0, tx_sh[FRAME_BITS-1:1]};
        end
    end

    // Drive the pad only inside a frame.
    always_ff @(posedge clk) begin
        if (!rst_n)       oe_q <= 1'b0;
        else if (cs_fall) oe_q <= 1'b1;
        else if (cs_rise) oe_q <= 1'b0;
    end

    assign sdo_oe  = oe_q;
    assign sdo_out = oe_q & tx_sh[0];

    assert_oe_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_low |=> !sdo_oe);
    assert_do_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_rise && !cs_fall && !cs_rise) |=> $stable(sdo_out));
endmodule

// File: rtl/ctl_status_shifter.sv
// Module: top of the serial control/status shifter. Synchronizes the serial
// pins, derives edge strobes and joins the receive and transmit paths.
// Assumes the serial clock is idle low and much slower than clk.
module ctl_status_shifter
    import css_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  csn_in,
    input  logic                  sclk_in,
    input  logic                  sdi_in,
    output logic                  sdo_out,
    output logic                  sdo_oe,
    input  logic                  prewarn,
    input  logic [NUM_OUT-1:0]    out_state,
    input  logic                  short_det,
    input  logic                  inhibit,
    input  logic                  supply_fail,
    output logic [FRAME_BITS-1:0] cmd_word,
    output logic                  status_clr
);
    logic [2:0]       pins_s;
    logic             cs_s, sclk_s, di_s;
    logic             cs_d, sclk_d;
    logic             cs_fall, cs_rise, sclk_fall, sclk_rise, cs_low;
    logic [CNT_W-1:0] bit_cnt;

    css_sync #(.WIDTH(3), .RST_VAL(3'b010)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({sdi_in, csn_in, sclk_in}),
        .q_sync  (pins_s)
    );
    assign {di_s, cs_s, sclk_s} = pins_s;

    // Delayed copies of the synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_d   <= 1'b1;
            sclk_d <= 1'b0;
        end else begin
            cs_d   <= cs_s;
            sclk_d <= sclk_s;
        end
    end

    assign cs_low    = !cs_s;
    assign cs_fall   = cs_d && !cs_s;
    assign cs_rise   = !cs_d && cs_s;
    assign sclk_fall = sclk_d && !sclk_s && cs_low;
    assign sclk_rise = !sclk_d && sclk_s && cs_low;

    css_rx i_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise),
        .sclk_fall (sclk_fall),
        .di        (di_s),
        .bit_cnt   (bit_cnt),
        .cmd_q     (cmd_word),
        .clr_pulse (status_clr)
    );

    css_tx i_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_low      (cs_low),
        .cs_fall     (cs_fall),
        .cs_rise     (cs_rise),
        .sclk_rise   (sclk_rise),
        .cnt_nz      (bit_cnt != '0),
        .status_word (pack_status(prewarn, out_state, short_det, inhibit, supply_fail)),
        .sdo_out     (sdo_out),
        .sdo_oe      (sdo_oe)
    );

    // A clear pulse may only follow a chip select rise.
    assert_clear_after_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        status_clr |-> $past(cs_rise));
    assert_no_output_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe |-> !sdo_out);
endmodule

// File: tb/test_ctl_status_shifter.sv
module test_ctl_status_shifter;
    logic clk = 0, rst_n = 0;
    logic csn = 1, sclk = 0, sdi = 0;
    logic pw = 0, sc = 0, inh = 0, sf = 0;
    logic [5:0] ost = 0;
    logic sdo, oe, clr;
    logic [15:0] cmd;
    int errors = 0, checks = 0, pulses = 0;
    logic [15:0] cmd_exp;

    always #10 clk = ~clk;

    ctl_status_shifter i_ctl_status_shifter (
        .clk(clk), .rst_n(rst_n), .csn_in(csn), .sclk_in(sclk), .sdi_in(sdi),
        .sdo_out(sdo), .sdo_oe(oe), .prewarn(pw), .out_state(ost),
        .short_det(sc), .inhibit(inh), .supply_fail(sf),
        .cmd_word(cmd), .status_clr(clr));

    always @(posedge clk) if (rst_n && clr) pulses++;

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // {nbits[4:0], status[9:0] = {sf,inh,sc,ost[5:0],pw}, word[15:0]}
    localparam int NV = 6;
    localparam logic [30:0] VEC [NV] = '{
        {5'd16, 10'h3FF, 16'h007E},
        {5'd16, 10'h155, 16'hA02B},
        {5'd10, 10'h2AA, 16'h0000},
        {5'd17, 10'h0F0, 16'hFFFF},
        {5'd16, 10'h301, 16'h5F81},
        {5'd0,  10'h001, 16'h1234}};

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] stat_word(input logic [9:0] s);
        return {s[9], s[8], s[7], 6'b0, s[6:1], s[0]};
    endfunction

    // Runs one frame; returns the bits read on DO (first min(n,16)).
    task automatic frame(input logic [15:0] w, input int n, input logic [9:0] s,
                         input bit change_mid, output logic [15:0] rd);
        {sf, inh, sc, ost, pw} = s;
        rd = '0;
        csn = 0; wclk(8);
        check("R3 bit0 at cs fall", {oe, sdo}, {1'b1, s[0]});
        for (int i = 0; i < n; i++) begin
            sdi = (i < 16) ? w[i] : 1'b1;
            sclk = 1; wclk(8);
            if (i < 16) rd[i] = sdo;
            if (change_mid && i == 3) {sf, inh, sc, ost, pw} = ~s;
            sclk = 0; wclk(8);
        end
        if (n > 0) check("R10 cmd unchanged before cs rise", cmd, cmd_exp);
        csn = 1; wclk(8);
    endtask

    initial begin
        logic [15:0] rd, mask;
        int p0;
        wclk(3);
        check("R1 reset cmd", cmd, 16'hE000);
        check("R1 reset oe/clr", {oe, clr}, 2'b00);
        rst_n = 1; wclk(5);
        check("R1 after release", {cmd, oe, clr}, {16'hE000, 2'b00});
        check("R2 idle output", {oe, sdo}, 2'b00);
        cmd_exp = 16'hE000;

        for (int v = 0; v < NV; v++) begin
            int n = int'(VEC[v][30:26]);
            p0 = pulses;
            frame(VEC[v][15:0], n, VEC[v][25:16], 0, rd);
            mask = (n >= 16) ? 16'hFFFF : 16'((1 << n) - 1);
            check("R4 status readback", rd & mask, stat_word(VEC[v][25:16]) & mask);
            if (n == 16) cmd_exp = VEC[v][15:0] & 16'hE07E;
            check(n == 16 ? "R5 commit" : (n > 16 ? "R7 long frame" : "R6 short frame"), cmd, cmd_exp);
            check("R8 clear pulse count", pulses - p0,
                  (n == 16 && VEC[v][0]) ? 1 : 0);
            check("R2 oe off after frame", {oe, sdo}, 2'b00);
        end

        // R9: inputs flip mid-frame; readback keeps the snapshot.
        frame(16'h8004, 16, 10'h2B3, 1, rd);
        check("R9 snapshot", rd, stat_word(10'h2B3));
        cmd_exp = 16'h8004;
        check("R5 commit run bit", cmd, cmd_exp);

        // R8: clear pulse width measured directly.
        p0 = pulses;
        frame(16'hE001, 16, 10'h000, 0, rd);
        cmd_exp = 16'hE000;
        check("R8 single cycle pulse", pulses - p0, 1);
        check("R8 bit0 not stored", cmd[0], 1'b0);

        // R6: early readout only (no clocks) leaves cmd.
        frame(16'h0000, 0, 10'h001, 0, rd);
        check("R6 early readout", cmd, cmd_exp);

        // R1: reset mid-life restores defaults.
        rst_n = 0; wclk(2);
        check("R1 re-reset", cmd, 16'hE000);
        rst_n = 1; wclk(4);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule